// File: doc/BRIEF.md
# Staged Audio Clock and Data Source Selector

This block routes audio sources to one converter of a multi-port audio interface. It picks one of five master clocks. It picks one of eight bit-clock/frame-clock pairs: five shared port pairs, the converter's own generated pair, a second playback converter's pair and the recording converter's pair. It also picks one of eight serial data inputs: five data pins, two general-purpose pins and the recording converter's serial output for loopback.

Software writes selection codes through a one-cycle write port into shadow fields. The live routing stays as it is until a write arrives with the commit bit set. That write applies all three selections at once.

Clock changes are glitch-free by default. The selector runs on a fast system clock that samples the audio clocks. It first gates the old source off at a moment when that source is low. It then gates the new source on at a moment when the new source is low. The output therefore stays low through the gap and never shows a shortened pulse. A force bit in the same write skips this wait and switches at once. A busy output shows that a gated change is still in progress.

Top module: `audio_route_sel`

## Requirements
- R1: After reset, every readback field is 0 and `busy` is 0. The master clock output follows `mclk_in[0]`, the pair outputs follow `bclk_in[0]`/`fclk_in[0]`, and the data output follows `din_in[0]`.
- R2: A master clock code of 0 to 4 (register bits [2:0]) routes `mclk_in[code]` to `mclk_out` once the switch completes.
- R3: A pair code (bits [5:3]) routes `bclk_in[code]`/`fclk_in[code]` to the pair outputs. Indices 0-4 are the shared port pairs, 5 is the converter's own generated pair, 6 is the second playback converter's pair and 7 is the recording converter's pair.
- R4: A data code (bits [8:6]) routes `din_in[code]` to `din_out`. Indices 0-4 are data pins, 5-6 are general-purpose pins 1-2, and 7 is the recording converter's serial output.
- R5: A write with the commit bit (bit 10) at 0 updates the readback fields but leaves all routing and `busy` unchanged.
- R6: A write with the commit bit at 1 stores the fields and, on the same clock edge, switches the data route and starts both clock changes.
- R7: With the force bit (bit 9) at 1 in a committing write, both clock routes take their new source from the cycle after the write, and `busy` is 0.
- R8: A committed master clock code of 5 to 7 leaves the master clock route unchanged. The other two fields still take effect, and the code still reads back.
- R9: With the force bit at 0, the old clock is disabled only while it is low and the new one is enabled only while it is low. The output never produces a high pulse shorter than a source half-period.
- R10: The commit bit always reads back as 0. Bits [9:0] read back the stored force, data, pair and master codes.
- R11: `busy` is 1 from the cycle after a non-forced commit that changes a clock source until the new source is enabled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 11 | Write value: master [2:0], pair [5:3], data [8:6], force [9], commit [10] |
| rd_data | output | 11 | Readback of the stored fields, commit bit reads 0 |
| mclk_in | input | 5 | Master clock candidates |
| bclk_in | input | 8 | Bit-clock candidates, indexed as in R3 |
| fclk_in | input | 8 | Frame-clock candidates, indexed as in R3 |
| din_in | input | 8 | Serial data candidates, indexed as in R4 |
| mclk_out | output | 1 | Routed master clock |
| bclk_out | output | 1 | Routed bit clock |
| fclk_out | output | 1 | Routed frame clock |
| din_out | output | 1 | Routed serial data |
| busy | output | 1 | A gated clock change is pending |

## Verification
The bench looks for the cases where a staged selector tends to go wrong.

- **Uncommitted write.** A write without the commit bit must leave the routing alone. A design that applied it early would move the data output at once.
- **Reserved master code.** A committed reserved code must not move the master clock. A design that took it would drive a dead, constant-low master clock.
- **Force bit.** A design that ignored the force bit would hold `busy` high after a forced commit.
- **Safe switching.** A design that switched mid-phase would show a one-cycle high pulse on the master clock during a gated change.
- **Commit-bit readback.** A design that stored the commit bit would read it back as 1.

// File: rtl/audio_route_sel.sv
module audio_route_sel #(
  parameter int SW    = 3,
  parameter int NMCLK = 5,
  parameter int RW    = 3*SW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_data,
  output logic [RW-1:0]        rd_data,
  input  logic [NMCLK-1:0]     mclk_in,
  input  logic [(1<<SW)-1:0]   bclk_in,
  input  logic [(1<<SW)-1:0]   fclk_in,
  input  logic [(1<<SW)-1:0]   din_in,
  output logic                 mclk_out,
  output logic                 bclk_out,
  output logic                 fclk_out,
  output logic                 din_out,
  output logic                 busy
);
  localparam int NS    = 1 << SW;
  localparam int F_BIT = 3*SW;
  localparam int C_BIT = 3*SW + 1;
  localparam logic [NS-1:0] ONE = NS'(1);

  typedef enum logic [1:0] {IDLE, DROP, RAISE} ph_t;

  logic [SW-1:0] sh_m, sh_p, sh_d;
  logic          sh_f;
  logic [SW-1:0] act_q;

  logic          commit, frc;
  logic [SW-1:0] w_m, w_p, w_d;
  logic          m_ok;

  assign commit = wr_en & wr_data[C_BIT];
  assign frc    = wr_data[F_BIT];
  assign w_m    = wr_data[SW-1:0];
  assign w_p    = wr_data[2*SW-1:SW];
  assign w_d    = wr_data[3*SW-1:2*SW];
  assign m_ok   = 32'(w_m) < NMCLK;

  logic [NS-1:0] src_v [2];
  logic          req_v [2];
  logic [SW-1:0] sel_v [2];
  logic [NS-1:0] en_q  [2];
  logic [SW-1:0] cur_q [2];
  logic [SW-1:0] tgt_q [2];
  ph_t           ph_q  [2];

  assign src_v[0] = NS'(mclk_in);
  assign src_v[1] = bclk_in;
  assign req_v[0] = commit & m_ok;
  assign req_v[1] = commit;
  assign sel_v[0] = w_m;
  assign sel_v[1] = w_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_m  <= '0;
      sh_p  <= '0;
      sh_d  <= '0;
      sh_f  <= 1'b0;
      act_q <= '0;
    end else if (wr_en) begin
      sh_m <= w_m;
      sh_p <= w_p;
      sh_d <= w_d;
      sh_f <= frc;
      if (commit) act_q <= w_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        en_q[p]  <= ONE;
        cur_q[p] <= '0;
        tgt_q[p] <= '0;
        ph_q[p]  <= IDLE;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (req_v[p] && frc) begin
          en_q[p]  <= ONE << sel_v[p];
          cur_q[p] <= sel_v[p];
          tgt_q[p] <= sel_v[p];
          ph_q[p]  <= IDLE;
        end else if (req_v[p]) begin
          tgt_q[p] <= sel_v[p];
          if (ph_q[p] == IDLE && sel_v[p] != cur_q[p]) ph_q[p] <= DROP;
        end else begin
          case (ph_q[p])
            DROP: if (!src_v[p][cur_q[p]]) begin
              en_q[p] <= '0;
              ph_q[p] <= RAISE;
            end
            RAISE: if (!src_v[p][tgt_q[p]]) begin
              en_q[p]  <= ONE << tgt_q[p];
              cur_q[p] <= tgt_q[p];
              ph_q[p]  <= IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_data  = RW'({1'b0, sh_f, sh_d, sh_p, sh_m});
  assign mclk_out = |(src_v[0] & en_q[0]);
  assign bclk_out = |(bclk_in & en_q[1]);
  assign fclk_out = |(fclk_in & en_q[1]);
  assign din_out  = din_in[act_q];
  assign busy     = (ph_q[0] != IDLE) | (ph_q[1] != IDLE);
endmodule

// File: rtl/audio_route_sel_chk.sv
module audio_route_sel_chk #(
  parameter int SW    = 3,
  parameter int NMCLK = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmt,
  input logic                frc,
  input logic [SW-1:0]       sel_m,
  input logic [SW-1:0]       sel_d,
  input logic                mclk_out,
  input logic                busy,
  input logic [SW-1:0]       act_d,
  input logic [SW-1:0]       m_tgt,
  input logic [(1<<SW)-1:0]  m_en
);
  a_r5_hold_route: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt |=> $stable(act_d));

  a_r6_commit_data: assert property (@(posedge clk) disable iff (!rst_n)
    cmt |=> act_d == $past(sel_d));

  a_r7_force_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt && frc && (32'(sel_m) < NMCLK)) |=> !busy);

  a_r8_reserved_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt && (32'(sel_m) >= NMCLK)) |=> $stable(m_tgt));

  a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_en));

  a_r9_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_en != $past(m_en)) && !$past(cmt && frc)) |-> !$past(mclk_out));
endmodule

bind audio_route_sel audio_route_sel_chk #(.SW(SW), .NMCLK(NMCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt(commit), .frc(frc), .sel_m(w_m), .sel_d(w_d),
  .mclk_out(mclk_out), .busy(busy), .act_d(act_q), .m_tgt(tgt_q[0]), .m_en(en_q[0])
);

// File: tb/sim_audio_route_sel.sv
module sim_audio_route_sel;
  localparam int K_RD = 0, K_MCLK = 1, K_PAIR = 2, K_DIN = 3, K_BUSY = 4;

  typedef struct {
    int          kind;
    int          idx;
    logic [10:0] val;
    string       req;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [10:0] wr_data = '0;
  logic [10:0] rd_data;
  logic [4:0]  mclk_in = '0;
  logic [7:0]  bclk_in = '0, fclk_in = '0, din_in = '0;
  logic        mclk_out, bclk_out, fclk_out, din_out, busy;

  int   compared = 0, mismatched = 0, tick = 0, hi_run = 0;
  logic chk_runt = 0;
  exp_t q[$];

  audio_route_sel u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mclk_in(mclk_in), .bclk_in(bclk_in), .fclk_in(fclk_in), .din_in(din_in),
    .mclk_out(mclk_out), .bclk_out(bclk_out), .fclk_out(fclk_out),
    .din_out(din_out), .busy(busy)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    #5;
    tick++;
    for (int i = 0; i < 5; i++) mclk_in[i] = ((tick / (i + 2)) % 2) == 1;
    for (int i = 0; i < 8; i++) begin
      bclk_in[i] = ((tick / (i + 2)) % 2) == 1;
      fclk_in[i] = ((tick / (8 * (i + 2))) % 2) == 1;
      din_in[i]  = (((tick / (i + 3)) + i) % 2) == 1;
    end
  end

  function automatic logic [10:0] enc(int m, int p, int d, bit f, bit c);
    return {c, f, 3'(d), 3'(p), 3'(m)};
  endfunction

  task automatic note(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  exp_t e;
  always @(posedge clk) begin
    #15;
    while (q.size() > 0) begin
      e = q.pop_front();
      case (e.kind)
        K_RD:   note(rd_data == e.val, e.req, "rd_data", int'(rd_data), int'(e.val));
        K_MCLK: note(mclk_out == mclk_in[e.idx], e.req, "mclk_out", int'(mclk_out), int'(mclk_in[e.idx]));
        K_PAIR: note({bclk_out, fclk_out} == {bclk_in[e.idx], fclk_in[e.idx]}, e.req, "bclk/fclk",
                     int'({bclk_out, fclk_out}), int'({bclk_in[e.idx], fclk_in[e.idx]}));
        K_DIN:  note(din_out == din_in[e.idx], e.req, "din_out", int'(din_out), int'(din_in[e.idx]));
        default: note(busy == e.val[0], e.req, "busy", int'(busy), int'(e.val[0]));
      endcase
    end
    if (mclk_out) hi_run++;
    else begin
      if (chk_runt && hi_run > 0) note(hi_run >= 2, "R9", "mclk high run", hi_run, 2);
      hi_run = 0;
    end
  end

  task automatic push(int k, int idx, logic [10:0] v, string r);
    exp_t x;
    x.kind = k; x.idx = idx; x.val = v; x.req = r;
    q.push_back(x);
  endtask

  task automatic follow(int k, int idx, int n, string r);
    repeat (n) begin
      push(k, idx, '0, r);
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(logic [10:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    push(K_RD, 0, '0, "R1");
    push(K_BUSY, 0, '0, "R1");
    follow(K_MCLK, 0, 8, "R1");
    follow(K_PAIR, 0, 8, "R1");
    follow(K_DIN, 0, 8, "R1");

    // R5 staged only
    wr(enc(3, 4, 5, 0, 0));
    push(K_RD, 0, enc(3, 4, 5, 0, 0), "R5");
    push(K_BUSY, 0, '0, "R5");
    follow(K_DIN, 0, 8, "R5");
    follow(K_MCLK, 0, 8, "R5");
    follow(K_PAIR, 0, 8, "R5");

    // R6 / R10 / R11 / R9 gated commit
    chk_runt = 1;
    wr(enc(3, 4, 5, 0, 1));
    push(K_RD, 0, enc(3, 4, 5, 0, 0), "R10");
    push(K_BUSY, 0, 11'd1, "R11");
    follow(K_DIN, 5, 8, "R6");
    wait_idle();
    push(K_BUSY, 0, '0, "R11");
    follow(K_MCLK, 3, 12, "R2");
    follow(K_PAIR, 4, 12, "R3");
    chk_runt = 0;

    // R7 forced commit
    wr(enc(1, 6, 7, 1, 1));
    push(K_BUSY, 0, '0, "R7");
    follow(K_MCLK, 1, 10, "R7");
    follow(K_PAIR, 6, 10, "R7");
    follow(K_DIN, 7, 8, "R4");

    // R8 reserved master code
    wr(enc(6, 2, 1, 1, 1));
    push(K_RD, 0, enc(6, 2, 1, 1, 0), "R8");
    follow(K_MCLK, 1, 10, "R8");
    follow(K_PAIR, 2, 10, "R8");
    follow(K_DIN, 1, 6, "R8");

    // R2/R3/R4 more codes through gated switching
    chk_runt = 1;
    wr(enc(4, 7, 6, 0, 1));
    wait_idle();
    follow(K_MCLK, 4, 12, "R2");
    follow(K_PAIR, 7, 12, "R3");
    follow(K_DIN, 6, 8, "R4");

    wr(enc(0, 5, 2, 0, 1));
    wait_idle();
    push(K_BUSY, 0, '0, "R11");
    follow(K_MCLK, 0, 12, "R2");
    follow(K_PAIR, 5, 12, "R3");
    follow(K_DIN, 2, 8, "R4");
    chk_runt = 0;

    // R8 reserved code, gated, pair unchanged: nothing pending
    wr(enc(7, 5, 3, 0, 1));
    push(K_BUSY, 0, '0, "R8");
    follow(K_MCLK, 0, 10, "R8");
    follow(K_DIN, 3, 6, "R4");

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule